// File: doc/BRIEF.md
# Hybrid-Scan Montgomery Modular Multiplier

This block computes the Montgomery product of two 128-bit residues, P = A·B·2^-128 mod n, for an odd modulus n. It is used as the modular multiply step of public-key arithmetic such as modular exponentiation or elliptic-curve point operations. The operands stay in Montgomery form between calls. The block does not compute the reduction constant: the caller supplies the low 32 bits k0 of the negated inverse of n.

Operands enter through one 32-bit port, one word per clock. A start pulse opens a load of thirteen words. A sequencer then runs a word schedule over four 32-bit words, and all of its arithmetic passes through a single 32×32 multiply-accumulate element. In the first pass the sequencer builds the lower triangle of the partial products, column by column. In the second pass each word-level reduction step alternates with the cross products of the upper triangle that land on the current top column. A word-serial conditional subtraction then brings the result below n. The block raises done for one cycle, and the result stays on its output until the next operation finishes.

Top module: `mont_cihs_top`

## Requirements
- R1: After synchronous reset, busy and done are low and result is zero.
- R2: A start is accepted only while busy is low. The word on din in the accepting cycle is word 0 of A. The next twelve cycles carry, one word per cycle, words 1 to 3 of A, words 0 to 3 of B, words 0 to 3 of n and then k0. Each operand is sent least significant word first, and k0 satisfies n[31:0]·k0 ≡ −1 mod 2^32.
- R3: For odd n and A, B < n, the result is A·B·2^-128 mod n.
- R4: The result is always below n. When the unreduced sum is at least n, including sums that exceed 2^128, n is subtracted exactly once.
- R5: done is high for exactly one cycle per operation. result changes only in the cycle in which done rises and holds its value until the next done.
- R6: busy is high from the cycle after an accepted start up to the cycle before done. A start seen while busy, whether held through the load or pulsed during the computation, starts no new operation and does not change the result.
- R7: With default parameters, done rises exactly 52 clock edges after the edge that accepted start, whatever the operand values.
- R8: A zero multiplicand gives a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when busy is low |
| din | input | 32 | Operand word stream |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 128 | Montgomery product, held between operations |

## Verification
The bench sweeps every operand pair for a tiny single-word modulus. There the upper words are zero, and a schedule that mis-indexes the cross products or drops the top-column carry would return nonzero garbage. Operands near a modulus just below 2^128 force sums at or above 2^128. A subtraction that ignored the overflow word, or applied the correction by borrow alone, would return a value at or above n. Random full-width moduli and the published vector catch a wrong load order or a k0 taken from the wrong word. The bench also holds start high through a load and pulses it mid-computation. A design that honoured those starts would emit an extra done, shift its latency, or corrupt the operands in use.

// File: rtl/mont_pkg.sv
package mont_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 4;
    localparam int OPER_W     = WORD_W * NUM_WORDS;
    localparam int LOAD_WORDS = 3 * NUM_WORDS + 1;
    localparam int LCNT_W     = $clog2(LOAD_WORDS);
    localparam int WSEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    // cycles from the accepting edge to the edge that raises done
    localparam int LOWER_STEPS  = NUM_WORDS * (NUM_WORDS + 1) / 2;
    localparam int REDUCE_STEPS = NUM_WORDS * (NUM_WORDS + 1);
    localparam int UPPER_STEPS  = NUM_WORDS * (NUM_WORDS - 1) / 2;
    localparam int LATENCY      = (LOAD_WORDS - 1) + LOWER_STEPS + REDUCE_STEPS
                                  + UPPER_STEPS + NUM_WORDS;

    typedef logic [WORD_W-1:0]           word_t;
    typedef word_t [NUM_WORDS-1:0]       opnd_t;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_LOWER,
        CS_MVAL,
        CS_REDUCE,
        CS_UPPER
    } core_st_e;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } mac_res_t;

endpackage

// File: rtl/mont_mac.sv
module mont_mac
    import mont_pkg::*;
(
    input  word_t    x,
    input  word_t    y,
    input  word_t    cin,
    input  word_t    tin,
    output mac_res_t res
);
    localparam logic [WORD_W-1:0] ZW = '0;

    logic [2*WORD_W-1:0] prod;
    logic [2*WORD_W-1:0] sum;

    always_comb begin
        prod = {ZW, x} * {ZW, y};
        sum  = prod + {ZW, cin} + {ZW, tin};
        res  = sum;
    end
endmodule

// File: rtl/mont_operand_regs.sv
module mont_operand_regs
    import mont_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t din,
    input  logic  busy,
    output opnd_t op_a,
    output opnd_t op_b,
    output opnd_t op_n,
    output word_t np0,
    output logic  load_act,
    output logic  load_last
);
    logic [LCNT_W-1:0] cnt;
    logic [1:0]        grp;
    logic [WSEL_W-1:0] wsel;
    logic              accept;

    assign accept    = start && !busy;
    assign load_last = load_act && (cnt == LCNT_W'(LOAD_WORDS - 1));

    always_comb begin
        grp  = 2'd3;
        wsel = '0;
        if (cnt < LCNT_W'(NUM_WORDS)) begin
            grp  = 2'd0;
            wsel = WSEL_W'(cnt);
        end else if (cnt < LCNT_W'(2 * NUM_WORDS)) begin
            grp  = 2'd1;
            wsel = WSEL_W'(cnt - LCNT_W'(NUM_WORDS));
        end else if (cnt < LCNT_W'(3 * NUM_WORDS)) begin
            grp  = 2'd2;
            wsel = WSEL_W'(cnt - LCNT_W'(2 * NUM_WORDS));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_act <= 1'b0;
            cnt      <= '0;
            op_a     <= '0;
            op_b     <= '0;
            op_n     <= '0;
            np0      <= '0;
        end else if (accept) begin
            load_act <= 1'b1;
            cnt      <= LCNT_W'(1);
            op_a[0]  <= din;
        end else if (load_act) begin
            case (grp)
                2'd0:    op_a[wsel] <= din;
                2'd1:    op_b[wsel] <= din;
                2'd2:    op_n[wsel] <= din;
                default: np0        <= din;
            endcase
            cnt <= cnt + LCNT_W'(1);
            if (load_last) load_act <= 1'b0;
        end
    end
endmodule

// File: rtl/mont_cihs_core.sv
module mont_cihs_core
    import mont_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  opnd_t op_a,
    input  opnd_t op_b,
    input  opnd_t op_n,
    input  word_t np0,
    output opnd_t acc_lo,
    output word_t acc_top,
    output logic  active,
    output logic  last_step
);
    localparam logic [WSEL_W-1:0] LASTW = WSEL_W'(NUM_WORDS - 1);
    localparam logic [WSEL_W-1:0] ONEW  = WSEL_W'(1);
    localparam logic [WORD_W-1:0] ZW    = '0;

    core_st_e          st;
    logic [WSEL_W-1:0] iw, jw;
    logic [WSEL_W-1:0] ij, jm1, aidx;
    logic [WSEL_W:0]   aidx_w;
    word_t             m_q, c_q, th0, th1;
    opnd_t             tl;
    word_t             mx, my, mc, mt;
    mac_res_t          mres;

    mont_mac u_mac (
        .x   (mx),
        .y   (my),
        .cin (mc),
        .tin (mt),
        .res (mres)
    );

    always_comb begin
        ij     = iw + jw;
        jm1    = jw - ONEW;
        aidx_w = (WSEL_W + 1)'(NUM_WORDS) + {1'b0, iw} - {1'b0, jw};
        aidx   = aidx_w[WSEL_W-1:0];
        mx = '0;
        my = '0;
        mc = '0;
        mt = '0;
        case (st)
            CS_LOWER: begin
                mx = op_a[jw];
                my = op_b[iw];
                mc = c_q;
                mt = tl[ij];
            end
            CS_MVAL: begin
                mx = tl[0];
                my = np0;
            end
            CS_REDUCE: begin
                mx = m_q;
                my = op_n[jw];
                mc = c_q;
                mt = tl[jw];
            end
            CS_UPPER: begin
                mx = op_b[jw];
                my = op_a[aidx];
                mt = tl[LASTW];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CS_IDLE;
            iw  <= '0;
            jw  <= '0;
            m_q <= '0;
            c_q <= '0;
            tl  <= '0;
            th0 <= '0;
            th1 <= '0;
        end else begin
            case (st)
                CS_IDLE: begin
                    if (go) begin
                        st  <= CS_LOWER;
                        iw  <= '0;
                        jw  <= '0;
                        c_q <= '0;
                        tl  <= '0;
                        th0 <= '0;
                        th1 <= '0;
                    end
                end
                CS_LOWER: begin
                    if (ij == LASTW) begin
                        // column NW-1 closes the row; its carry goes to the top pair
                        tl[LASTW]  <= mres.lo;
                        {th1, th0} <= {th1, th0} + {ZW, mres.hi};
                        c_q        <= '0;
                        jw         <= '0;
                        if (iw == LASTW) begin
                            iw <= '0;
                            st <= CS_MVAL;
                        end else begin
                            iw <= iw + ONEW;
                        end
                    end else begin
                        tl[ij] <= mres.lo;
                        c_q    <= mres.hi;
                        jw     <= jw + ONEW;
                    end
                end
                CS_MVAL: begin
                    m_q <= mres.lo;
                    c_q <= '0;
                    jw  <= '0;
                    st  <= CS_REDUCE;
                end
                CS_REDUCE: begin
                    // word j lands one position lower: the shift by one word
                    if (jw != '0) tl[jm1] <= mres.lo;
                    if (jw == LASTW) begin
                        {th0, tl[LASTW]} <= {th1, th0} + {ZW, mres.hi};
                        th1 <= '0;
                        c_q <= '0;
                        if (iw == LASTW) begin
                            st <= CS_IDLE;
                        end else begin
                            st <= CS_UPPER;
                            jw <= iw + ONEW;
                        end
                    end else begin
                        c_q <= mres.hi;
                        jw  <= jw + ONEW;
                    end
                end
                CS_UPPER: begin
                    tl[LASTW]  <= mres.lo;
                    {th1, th0} <= {th1, th0} + {ZW, mres.hi};
                    if (jw == LASTW) begin
                        iw <= iw + ONEW;
                        st <= CS_MVAL;
                    end else begin
                        jw <= jw + ONEW;
                    end
                end
                default: st <= CS_IDLE;
            endcase
        end
    end

    assign acc_lo    = tl;
    assign acc_top   = th0;
    assign active    = (st != CS_IDLE);
    assign last_step = (st == CS_REDUCE) && (jw == LASTW) && (iw == LASTW);
endmodule

// File: rtl/mont_final_sub.sv
module mont_final_sub
    import mont_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  opnd_t u_lo,
    input  word_t u_top,
    input  opnd_t op_n,
    output opnd_t res,
    output logic  done,
    output logic  active
);
    localparam logic [WSEL_W-1:0] LASTW = WSEL_W'(NUM_WORDS - 1);

    logic [WSEL_W-1:0] k;
    logic              brw;
    opnd_t             diff;
    opnd_t             diff_full;
    logic [WORD_W:0]   dsub;
    logic              ge;

    always_comb begin
        dsub = {1'b0, u_lo[k]} - {1'b0, op_n[k]} - {{WORD_W{1'b0}}, brw};
        diff_full    = diff;
        diff_full[k] = dsub[WORD_W-1:0];
        ge = (u_top != '0) || !dsub[WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k      <= '0;
            brw    <= 1'b0;
            diff   <= '0;
            res    <= '0;
            done   <= 1'b0;
            active <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                k      <= '0;
                brw    <= 1'b0;
            end else if (active) begin
                diff[k] <= dsub[WORD_W-1:0];
                brw     <= dsub[WORD_W];
                k       <= k + WSEL_W'(1);
                if (k == LASTW) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    res    <= ge ? diff_full : u_lo;
                end
            end
        end
    end
endmodule

// File: rtl/mont_cihs_top.sv
module mont_cihs_top
    import mont_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] din,
    output logic              busy,
    output logic              done,
    output logic [OPER_W-1:0] result
);
    opnd_t op_a, op_b, op_n, acc_lo, res_w;
    word_t np0, acc_top;
    logic  load_act, load_last, core_act, core_last, sub_act;

    assign busy   = load_act | core_act | sub_act;
    assign result = res_w;

    mont_operand_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .din       (din),
        .busy      (busy),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_n      (op_n),
        .np0       (np0),
        .load_act  (load_act),
        .load_last (load_last)
    );

    mont_cihs_core u_core (
        .clk       (clk),
        .rst       (rst),
        .go        (load_last),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_n      (op_n),
        .np0       (np0),
        .acc_lo    (acc_lo),
        .acc_top   (acc_top),
        .active    (core_act),
        .last_step (core_last)
    );

    mont_final_sub u_sub (
        .clk    (clk),
        .rst    (rst),
        .go     (core_last),
        .u_lo   (acc_lo),
        .u_top  (acc_top),
        .op_n   (op_n),
        .res    (res_w),
        .done   (done),
        .active (sub_act)
    );
endmodule

// File: rtl/mont_cihs_chk.sv
module mont_cihs_chk
    import mont_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [OPER_W-1:0] result,
    input logic [OPER_W-1:0] modulus,
    input logic              load_act,
    input logic              core_act,
    input logic              sub_act,
    input logic [WORD_W-1:0] acc_top
);
    localparam int LAT_W = $clog2(LATENCY + 2);

    logic [LAT_W-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= '0;
        else if (busy) lat_cnt <= lat_cnt + LAT_W'(1);
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_one_phase_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_act, core_act, sub_act}));

    assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_idle_at_done_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_below_modulus_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (result < modulus));

    assert_top_word_small_R3: assert property (@(posedge clk) disable iff (rst)
        sub_act |-> (acc_top <= WORD_W'(1)));

    assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == LAT_W'(LATENCY)));
endmodule

bind mont_cihs_top mont_cihs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .modulus  (op_n),
    .load_act (load_act),
    .core_act (core_act),
    .sub_act  (sub_act),
    .acc_top  (acc_top)
);

// File: tb/tb_mont_cihs_top.sv
`timescale 1ns/1ps
module tb_mont_cihs_top;
    import mont_pkg::*;

    localparam int EXP_LAT = 52;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [WORD_W-1:0] din = '0;
    logic              busy, done;
    logic [OPER_W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    mont_cihs_top dut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .din    (din),
        .busy   (busy),
        .done   (done),
        .result (result)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // radix-2 Montgomery product, independent of the word schedule
    function automatic logic [127:0] mont_ref(input logic [127:0] a, b, n);
        logic [129:0] u;
        u = '0;
        for (int k = 0; k < 128; k++) begin
            if (a[k]) u = u + {2'b00, b};
            if (u[0]) u = u + {2'b00, n};
            u = u >> 1;
        end
        if (u >= {2'b00, n}) u = u - {2'b00, n};
        return u[127:0];
    endfunction

    function automatic logic [31:0] neg_inv(input logic [31:0] n0);
        logic [31:0] x;
        x = n0;
        for (int k = 0; k < 5; k++) x = x * (32'd2 - n0 * x);
        return -x;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic run_op(input logic [127:0] a, b, n, input bit hold_start,
                          input bit poke, input string tag);
        logic [415:0]  stream;
        logic [127:0]  exp, held;
        int            c0, waited, lat;
        exp    = mont_ref(a, b, n);
        stream = {neg_inv(n[31:0]), n, b, a};
        @(negedge clk);
        start = 1'b1;
        din   = stream[31:0];
        c0    = cyc;
        for (int k = 1; k < 13; k++) begin
            @(negedge clk);
            start = hold_start;
            din   = stream[32*k +: 32];
        end
        waited = 0;
        while (done !== 1'b1 && waited < 200) begin
            @(negedge clk);
            start = (poke && waited == 5) ? 1'b1 : 1'b0;
            din   = $urandom;
            waited++;
        end
        start = 1'b0;
        if (done !== 1'b1) begin
            check(1'b0, "R7", {tag, " done never seen"}, 0, 1);
        end else begin
            lat = cyc - c0 - 1;
            check(lat == EXP_LAT, "R7", {tag, " latency"}, lat, EXP_LAT);
            check(result === exp, "R3", {tag, " product"}, result, exp);
            check(result < n, "R4", {tag, " reduced below n"}, result, n);
            held = result;
            @(negedge clk);
            check(done === 1'b0, "R5", {tag, " done width"}, done, 0);
            repeat (3) @(negedge clk);
            check(result === held, "R5", {tag, " result held"}, result, held);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] n, a, b, r;
        int           extra;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy after reset", busy, 0);
        check(done === 1'b0, "R1", "done after reset", done, 0);
        check(result === '0, "R1", "result after reset", result, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2, R3: published vector, checks word order and k0 usage
        n = 128'heee74404d129949520704c5bf5814703;
        a = 128'h223520375bd184b2bac64c9d1a6c55fa;
        b = 128'hd857ed0720d590d61f05c150e1e40917;
        check(neg_inv(n[31:0]) === 32'hd65d2455, "R2", "k0 derivation", neg_inv(n[31:0]), 32'hd65d2455);
        run_op(a, b, n, 1'b0, 1'b0, "vector");
        check(result === 128'he3bd635debc8021ea0208d75df078ea6, "R2", "vector constant",
              result, 128'he3bd635debc8021ea0208d75df078ea6);

        // R8: zero multiplicand
        run_op('0, b, n, 1'b0, 1'b0, "zero");
        check(result === '0, "R8", "zero operand", result, 0);
        // R3: unit operands and the largest residue
        run_op(128'd1, 128'd1, n, 1'b0, 1'b0, "unit");
        run_op(n - 1, n - 1, n, 1'b0, 1'b0, "max");

        // R6: start held through the load, then pulsed mid-run
        run_op(a, b, n, 1'b1, 1'b0, "held start");
        check(result === 128'he3bd635debc8021ea0208d75df078ea6, "R6", "held start result",
              result, 128'he3bd635debc8021ea0208d75df078ea6);
        run_op(b, a, n, 1'b0, 1'b1, "poked start");
        r = result;
        extra = 0;
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            if (done === 1'b1 || busy === 1'b1) extra++;
        end
        check(extra == 0, "R6", "no operation from ignored start", extra, 0);
        check(result === r, "R6", "result untouched by ignored start", result, r);

        // R3, R4: exhaustive sweep over a tiny modulus
        n = 128'd13;
        for (int x = 0; x < 13; x++) begin
            for (int y = 0; y < 13; y++) begin
                run_op(128'(x), 128'(y), n, 1'b0, 1'b0, "small sweep");
            end
        end

        // R4: modulus just below 2^128, sums above 2^128
        n = '1 - 128'd158;
        run_op(n - 1, n - 2, n, 1'b0, 1'b0, "top pair");
        for (int k = 0; k < 20; k++) begin
            a = rnd128() % n;
            b = rnd128() % n;
            run_op(a, b, n, 1'b0, 1'b0, "near 2^128");
        end

        // R3: random full-width odd moduli
        for (int k = 0; k < 30; k++) begin
            n = rnd128() | 128'd1;
            n[127] = (k % 3) != 0;
            a = rnd128() % n;
            b = rnd128() % n;
            run_op(a, b, n, 1'b0, 1'b0, "random");
        end

        summary();
        $finish;
    end
endmodule